// File: doc/BRIEF.md
# PCI Target Read-Burst Output Stage

This block is the part of a PCI target that drives read data during a burst. Once an external address decoder reports a hit on a read, the stage claims the bus with DEVSEL#, turns the AD lines around, and presents words taken from a local prefetch source. The source shows its head word together with a valid flag. The stage pops that word with a single take strobe.

The AD output register is clock-enabled from the data-phase completion term (IRDY# and TRDY# both low). The word on the bus therefore stays put through initiator wait states and changes only after a phase completes. TRDY# is registered and computed without reference to the initiator's IRDY#, so the two sides cannot wait on each other. A half-rate mode leaves TRDY# high for one clock after each new word is loaded. The target then sees IRDY# before it commits to that word, at the cost of halving peak throughput.

After the final phase completes (FRAME# high with IRDY# and TRDY# low), DEVSEL# and TRDY# are driven high for one turnaround clock. They are then released, together with AD.

Top module: `pci_rdburst_out`

## Requirements
- R1: While rst_n is low and on the first clock after it, devsel_oe, trdy_oe and ad_oe are 0 and word_take is 0.
- R2: A hit sampled while the stage is idle makes devsel_oe=1, devsel_n_o=0, trdy_n_o=1 and ad_oe=0 on the next clock, and ad_oe=1 on the clock after that. A hit sampled while the stage is claimed or in turnaround is ignored.
- R3: TRDY# (trdy_n_o, active low) is asserted only while ad_oe=1 and a word is loaded. It asserts without the initiator ever asserting IRDY#: in full-speed mode, two clocks after the hit when word_valid is high.
- R4: On a clock where trdy_n_o=0 and irdy_n=1, ad_o and trdy_n_o are unchanged on the next clock.
- R5: A completed data phase transfers the words in source order with none skipped or repeated. word_take rises only with word_valid and never on the final phase's completion. Per burst, the number of takes equals the number of data phases.
- R6: With half_rate=0, after a non-final completion in which a new word was taken, trdy_n_o stays 0 on the next clock. If no word was available, trdy_n_o is 1 on the next clock.
- R7: With half_rate=1, trdy_n_o is 1 on the clock after every word taken from the source.
- R8: After the final phase completes, the next clock has devsel_oe=1, trdy_oe=1, devsel_n_o=1, trdy_n_o=1 and ad_oe=0. On the clock after that, devsel_oe=0 and trdy_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_rate | input | 1 | 1 selects one word per two clocks; held static during a burst |
| hit | input | 1 | Address decoder reports a read claim during the address phase |
| frame_n | input | 1 | FRAME# from the bus, active low |
| irdy_n | input | 1 | IRDY# from the bus, active low |
| word_data | input | DATA_W | Head word of the local prefetch source |
| word_valid | input | 1 | Head word is present |
| word_take | output | 1 | Pops the head word this clock |
| ad_o | output | DATA_W | AD output value |
| ad_oe | output | 1 | AD output enable |
| trdy_n_o | output | 1 | TRDY# value, active low |
| trdy_oe | output | 1 | TRDY# output enable |
| devsel_n_o | output | 1 | DEVSEL# value, active low |
| devsel_oe | output | 1 | DEVSEL# output enable |

## Verification
The assertions rely on a well-behaved initiator. Once IRDY# is asserted, it stays low until the phase completes. FRAME# rises only on a clock where IRDY# is low for the last phase. A hit arrives only with FRAME# low and IRDY# high. Mode changes happen only between bursts. The bench initiator follows these rules at every step. It holds IRDY# low after asserting it, and it raises FRAME# only when it asserts IRDY# for the last phase. Within those rules it randomizes burst lengths, wait states and source gaps, and it also places hits inside bursts and in the turnaround clock.

// File: rtl/pci_rdburst_out.sv
module pci_rdburst_out #(
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              half_rate,
  input  logic              hit,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [DATA_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_take,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic              trdy_n_o,
  output logic              trdy_oe,
  output logic              devsel_n_o,
  output logic              devsel_oe
);

  logic              claimed, turn, oe_q, held, go;
  logic [DATA_W-1:0] ad_q;
  logic              xfer, final_x, refill, load, live_n, held_n;

  assign xfer    = go & ~irdy_n;
  assign final_x = xfer & frame_n;
  assign live_n  = claimed & ~final_x;
  assign refill  = live_n & (xfer | ~held);
  assign load    = refill & word_valid;
  assign held_n  = final_x ? 1'b0 : (refill ? word_valid : held);

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      claimed <= 1'b0;
      turn    <= 1'b0;
      oe_q    <= 1'b0;
      held    <= 1'b0;
      go      <= 1'b0;
    end else begin
      claimed <= claimed ? ~final_x : (hit & ~turn);
      turn    <= final_x;
      oe_q    <= live_n;
      held    <= held_n;
      go      <= live_n & held_n & ~(half_rate & load);
    end
  end

  always_ff @(posedge pclk) begin
    if (load) ad_q <= word_data;
  end

  assign word_take  = load;
  assign ad_o       = ad_q;
  assign ad_oe      = oe_q;
  assign trdy_n_o   = ~go;
  assign trdy_oe    = claimed | turn;
  assign devsel_n_o = ~claimed;
  assign devsel_oe  = claimed | turn;

  // R1
  reset_quiet_chk: assert property (@(posedge pclk) !rst_n |=> (!devsel_oe && !trdy_oe && !ad_oe && !word_take));

  // R2
  oe_after_claim_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (devsel_oe && !devsel_n_o && !ad_oe) |=> ad_oe);

  // R3
  trdy_needs_bus_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    !trdy_n_o |-> (ad_oe && !devsel_n_o));

  // R4
  wait_hold_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!trdy_n_o && irdy_n) |=> (!trdy_n_o && $stable(ad_o)));

  // R5
  no_final_pop_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!trdy_n_o && !irdy_n && frame_n) |-> !word_take);

  // R5
  pop_on_phase_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!trdy_n_o && !irdy_n && !frame_n && word_valid) |-> word_take);

  // R7
  half_gap_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (half_rate && word_take) |=> trdy_n_o);

  // R8
  turnaround_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!trdy_n_o && !irdy_n && frame_n) |=> (devsel_oe && trdy_oe && devsel_n_o && trdy_n_o && !ad_oe));

  // R8
  release_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (!trdy_n_o && !irdy_n && frame_n) |=> ##1 (!devsel_oe && !trdy_oe));

endmodule

// File: tb/pci_rdburst_out_tb.sv
module pci_rdburst_out_tb;
  logic        clk = 1'b0;
  logic        rst_n, half_rate, hit, frame_n, irdy_n, word_valid;
  logic [31:0] word_data;
  logic        word_take, ad_oe, trdy_n_o, trdy_oe, devsel_n_o, devsel_oe;
  logic [31:0] ad_o;

  pci_rdburst_out #(.DATA_W(32)) u_dut (
    .pclk(clk), .rst_n(rst_n), .half_rate(half_rate), .hit(hit),
    .frame_n(frame_n), .irdy_n(irdy_n), .word_data(word_data),
    .word_valid(word_valid), .word_take(word_take), .ad_o(ad_o),
    .ad_oe(ad_oe), .trdy_n_o(trdy_n_o), .trdy_oe(trdy_oe),
    .devsel_n_o(devsel_n_o), .devsel_oe(devsel_oe)
  );

  always #5 clk = ~clk;

  int vec = 0, bad = 0, cycles = 0, src_idx = 0, xfer_idx = 0, pops = 0, valid_pct = 100;
  bit timeout = 0, finished = 0;
  bit p_last, p2_last, p_hold, p_nf, p_loaded, p_claim, p2_claim;
  logic [31:0] p_ad;
  logic o_trdy, o_trdy_oe, o_dev_oe, o_dev_n, o_ad_oe;
  logic [31:0] o_ad;

  function automatic logic [31:0] gen(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic step(input bit f, input bit ir, input bit h, output bit xf);
    bit tk;
    @(negedge clk);
    cycles++;
    if (cycles > 150000) timeout = 1;
    o_trdy = trdy_n_o; o_trdy_oe = trdy_oe; o_dev_oe = devsel_oe;
    o_dev_n = devsel_n_o; o_ad_oe = ad_oe; o_ad = ad_o;
    if (p_claim)
      chk(o_dev_oe && !o_dev_n && o_trdy && !o_ad_oe, "R2 claim",
          {o_dev_oe, o_dev_n, o_trdy, o_ad_oe}, 4'b1010);
    if (p2_claim && !p_claim) chk(o_ad_oe, "R2 ad_oe", o_ad_oe, 1);
    if (p_last)
      chk(o_dev_oe && o_trdy_oe && o_dev_n && o_trdy && !o_ad_oe, "R8 turnaround",
          {o_dev_oe, o_trdy_oe, o_dev_n, o_trdy, o_ad_oe}, 5'b11110);
    if (p2_last)
      chk(!o_dev_oe && !o_trdy_oe, "R8 R2 release", {o_dev_oe, o_trdy_oe}, 0);
    if (p_hold)
      chk(o_ad == p_ad && !o_trdy, "R4 hold", o_ad, p_ad);
    if (p_nf) begin
      if (!p_loaded) chk(o_trdy, "R6 empty", o_trdy, 1);
      else if (half_rate) chk(o_trdy, "R7 half gap", o_trdy, 1);
      else chk(!o_trdy, "R6 full speed", o_trdy, 0);
    end
    frame_n = f; irdy_n = ir; hit = h;
    word_valid = ($urandom % 100) < valid_pct;
    word_data = gen(src_idx);
    #1;
    xf = !o_trdy && o_trdy_oe && !ir;
    if (xf) begin
      chk(o_ad_oe && o_ad == gen(xfer_idx), "R5 order", o_ad, gen(xfer_idx));
      xfer_idx++;
    end
    tk = word_take;
    if (tk && word_valid) begin src_idx++; pops++; end
    p2_last = p_last; p_last = xf && f;
    p_hold = !o_trdy && o_dev_oe && !xf;
    p_ad = o_ad;
    p_nf = xf && !f;
    p_loaded = tk && word_valid;
    p2_claim = p_claim; p_claim = h && !o_dev_oe;
  endtask

  task automatic burst(input int len, input int ir_delay, input bit r3chk, input bit turn_hit);
    int n = 0, k = 0;
    bit held_ir = 0, xf, ir, last, f;
    pops = 0;
    step(0, 1, 1, xf);
    while (n < len && !timeout) begin
      if (held_ir) ir = 0;
      else if (k < ir_delay) ir = 1;
      else ir = ($urandom % 3) == 0;
      last = (n == len - 1);
      f = last && !ir;
      step(f, ir, ($urandom % 8) == 0, xf);
      if (r3chk && k == 1) chk(!o_trdy, "R3 no irdy needed", o_trdy, 0);
      if (xf) n++;
      held_ir = !ir && !xf;
      k++;
    end
    step(1, 1, turn_hit, xf);
    step(1, 1, 0, xf);
    chk(pops == len, "R5 take count", pops, len);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      bad++; vec++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    bit xf;
    void'($urandom(32'd1234));
    rst_n = 0; half_rate = 0; hit = 0; frame_n = 1; irdy_n = 1; word_valid = 0; word_data = 0;
    repeat (3) @(negedge clk);
    chk(!devsel_oe && !trdy_oe && !ad_oe && !word_take, "R1 reset",
        {devsel_oe, trdy_oe, ad_oe, word_take}, 0);
    @(negedge clk); rst_n = 1;
    step(1, 1, 0, xf);
    chk(!devsel_oe && !trdy_oe && !ad_oe, "R1 idle after reset", {devsel_oe, trdy_oe, ad_oe}, 0);

    valid_pct = 100;
    burst(1, 0, 0, 1);
    burst(5, 4, 1, 0);
    burst(8, 0, 0, 1);
    valid_pct = 30;
    burst(6, 0, 0, 0);
    half_rate = 1; valid_pct = 100;
    burst(6, 0, 0, 1);
    burst(1, 2, 0, 0);
    valid_pct = 50;
    burst(7, 0, 0, 0);

    for (int i = 0; i < 150 && !timeout; i++) begin
      half_rate = $urandom % 2;
      valid_pct = 40 + ($urandom % 61);
      burst(1 + ($urandom % 8), $urandom % 3, 0, $urandom % 2);
    end

    if (timeout) begin
      bad++; vec++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule